// File: doc/BRIEF.md
# Byte/Word Memory Bus Front-End

This block sits between the host pins of a parallel non-volatile memory and its internal logic. It watches three active-low strobes (chip select, write strobe, read strobe) and a reset/lock pin. It samples them with the system clock through a two-stage synchronizer and finds the start and end of each write cycle. A write cycle is the interval in which chip select and write strobe are both low. The address is taken when that interval opens, and the data when it closes. Each completed write goes to the internal command logic as a single-cycle pulse that carries the byte address, the data and the width mode.

A static width pin selects between a 16-bit and an 8-bit data path. In 8-bit mode the top data pin becomes an extra least-significant address input and the upper lanes are released. For reads, the block passes the host address to an internal data source. It then places either the returned array word (or one half of it) or a status byte onto the data bus. Each data bit has its own drive enable.

Top module: `mem_bus_front`

## Requirements
- R1: The address is latched when chip select and write strobe first become low together, so the later of the two falling strobes controls the capture, whichever one it is.
- R2: Write data is latched when chip select and write strobe stop being low together (the first strobe to rise). At that point `cmd_valid_o` pulses high for exactly one clock, carrying `cmd_addr_o`, `cmd_data_o` and `cmd_byte_o`.
- R3: With `byte_n` low at address capture, `cmd_addr_o` = {addr_i, dq_i[15]}, `cmd_byte_o` = 1 and `cmd_data_o` = {8'h00, dq_i[7:0]}. With `byte_n` high, `cmd_addr_o` = {1'b0, addr_i}, `cmd_byte_o` = 0 and `cmd_data_o` = dq_i[15:0].
- R4: The data drivers turn on only while the synchronized chip select and read strobe are low, the write strobe is high and `rp_n` is high. Outputs follow a pin change after three clock edges (two synchronizer stages and one output register).
- R5: `dq_oe_o` is 16'hFFFF when driving in word mode, 16'h00FF when driving in byte mode, and 16'h0000 otherwise. `dq_o` is all zero whenever `dq_oe_o` is zero.
- R6: A byte-mode array read places rd_data_i[15:8] on dq_o[7:0] when dq_i[15] is 1, and rd_data_i[7:0] when it is 0. dq_o[15:8] is zero. `rd_addr_o` always equals `addr_i`.
- R7: When `rd_status_i` is 1, a read returns `status_i` on dq_o[7:0] and zero on dq_o[15:8], in both modes.
- R8: While the synchronized `rp_n` is low, the drivers are off and a write that ends produces no `cmd_valid_o` pulse.
- R9: When the write strobe and read strobe are low together with chip select, the cycle is treated as a write and the drivers stay off.
- R10: After reset, `dq_oe_o`, `dq_o`, `cmd_valid_o`, `cmd_addr_o` and `cmd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Chip select strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| rp_n | input | 1 | Reset/lock pin, low blocks the bus |
| byte_n | input | 1 | Width mode: 0 = 8-bit, 1 = 16-bit |
| addr_i | input | ADDR_W | Host word address |
| dq_i | input | 16 | Data pins, input side (bit 15 is the low address bit in 8-bit mode) |
| dq_o | output | 16 | Data pins, output side |
| dq_oe_o | output | 16 | Per-bit drive enable |
| rd_addr_o | output | ADDR_W | Address to the internal read source |
| rd_data_i | input | 16 | Array word from the internal read source |
| rd_status_i | input | 1 | 1 = return status instead of array data |
| status_i | input | 8 | Status byte |
| cmd_valid_o | output | 1 | One-cycle write pulse to the command logic |
| cmd_addr_o | output | ADDR_W+1 | Latched byte address of the write |
| cmd_data_o | output | 16 | Latched write data |
| cmd_byte_o | output | 1 | Width mode of the write |

## Verification
The assertions take the strobes to be held stable for at least three clocks around each change. They also take the address, `dq_i[15]` and `byte_n` to be steady from before a write opens until it closes, and the data lanes to be steady until three clocks after it closes. Every bench task sets up the address and data before it moves a strobe and waits at least four clocks between strobe moves. This covers writes led by either strobe, reads, overlaps, and `rp_n` pulses, so each synchronized edge samples settled pin values.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
    localparam int unsigned DQ_W   = 16;
    localparam int unsigned HALF_W = DQ_W / 2;

    typedef struct packed {
        logic [DQ_W-1:0] dq;
        logic [DQ_W-1:0] oe;
    } drv_t;
endpackage

// File: rtl/mbf_sync.sv
module mbf_sync #(
    parameter int unsigned N = 4,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/mbf_wr.sv
module mbf_wr #(
    parameter int unsigned ADDR_W = 19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce_s,
    input  logic                     we_s,
    input  logic                     rp_s,
    input  logic                     byte_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [mbf_pkg::DQ_W-1:0] dq_i,
    output logic                     cmd_valid_o,
    output logic [ADDR_W:0]          cmd_addr_o,
    output logic [mbf_pkg::DQ_W-1:0] cmd_data_o,
    output logic                     cmd_byte_o
);
    import mbf_pkg::*;

    typedef struct packed {
        logic              act;
        logic              bmode;
        logic [ADDR_W:0]   addr;
        logic              vld;
        logic [DQ_W-1:0]   data;
    } wr_t;

    wr_t  st_d, st_q;
    logic act_now;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        act_now  = !ce_s && !we_s;
        st_d.act = act_now;
        if (act_now && !st_q.act) begin
            st_d.bmode = !byte_n;
            st_d.addr  = byte_n ? {1'b0, addr_i} : {addr_i, dq_i[DQ_W-1]};
        end
        if (!act_now && st_q.act && rp_s) begin
            st_d.vld  = 1'b1;
            st_d.data = st_q.bmode ? {{HALF_W{1'b0}}, dq_i[HALF_W-1:0]} : dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid_o = st_q.vld;
    assign cmd_addr_o  = st_q.addr;
    assign cmd_data_o  = st_q.data;
    assign cmd_byte_o  = st_q.bmode;
endmodule

// File: rtl/mbf_rd.sv
module mbf_rd (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_s,
    input  logic                       oe_s,
    input  logic                       we_s,
    input  logic                       rp_s,
    input  logic                       byte_n,
    input  logic                       lsb_i,
    input  logic [mbf_pkg::DQ_W-1:0]   rd_data_i,
    input  logic                       rd_status_i,
    input  logic [mbf_pkg::HALF_W-1:0] status_i,
    output logic [mbf_pkg::DQ_W-1:0]   dq_o,
    output logic [mbf_pkg::DQ_W-1:0]   dq_oe_o
);
    import mbf_pkg::*;

    drv_t drv_d, drv_q;
    logic en;

    always_comb begin
        drv_d = '0;
        en    = !ce_s && !oe_s && we_s && rp_s;
        if (en) begin
            if (byte_n) begin
                drv_d.oe = '1;
                drv_d.dq = rd_status_i ? {{HALF_W{1'b0}}, status_i} : rd_data_i;
            end else begin
                drv_d.oe = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
                if (rd_status_i) begin
                    drv_d.dq[HALF_W-1:0] = status_i;
                end else if (lsb_i) begin
                    drv_d.dq[HALF_W-1:0] = rd_data_i[DQ_W-1:HALF_W];
                end else begin
                    drv_d.dq[HALF_W-1:0] = rd_data_i[HALF_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign dq_o    = drv_q.dq;
    assign dq_oe_o = drv_q.oe;
endmodule

// File: rtl/mem_bus_front.sv
module mem_bus_front #(
    parameter int unsigned ADDR_W = 19
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_n,
    input  logic                       we_n,
    input  logic                       oe_n,
    input  logic                       rp_n,
    input  logic                       byte_n,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [mbf_pkg::DQ_W-1:0]   dq_i,
    output logic [mbf_pkg::DQ_W-1:0]   dq_o,
    output logic [mbf_pkg::DQ_W-1:0]   dq_oe_o,
    output logic [ADDR_W-1:0]          rd_addr_o,
    input  logic [mbf_pkg::DQ_W-1:0]   rd_data_i,
    input  logic                       rd_status_i,
    input  logic [mbf_pkg::HALF_W-1:0] status_i,
    output logic                       cmd_valid_o,
    output logic [ADDR_W:0]            cmd_addr_o,
    output logic [mbf_pkg::DQ_W-1:0]   cmd_data_o,
    output logic                       cmd_byte_o
);
    import mbf_pkg::*;

    localparam int unsigned NSTRB = 4;

    logic [NSTRB-1:0] strb_s;
    logic             ce_s, we_s, oe_s, rp_s;

    mbf_sync #(.N(NSTRB), .RST_VAL({NSTRB{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({rp_n, oe_n, we_n, ce_n}),
        .q_o   (strb_s)
    );

    assign ce_s = strb_s[0];
    assign we_s = strb_s[1];
    assign oe_s = strb_s[2];
    assign rp_s = strb_s[3];

    mbf_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_s        (ce_s),
        .we_s        (we_s),
        .rp_s        (rp_s),
        .byte_n      (byte_n),
        .addr_i      (addr_i),
        .dq_i        (dq_i),
        .cmd_valid_o (cmd_valid_o),
        .cmd_addr_o  (cmd_addr_o),
        .cmd_data_o  (cmd_data_o),
        .cmd_byte_o  (cmd_byte_o)
    );

    mbf_rd u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_s        (ce_s),
        .oe_s        (oe_s),
        .we_s        (we_s),
        .rp_s        (rp_s),
        .byte_n      (byte_n),
        .lsb_i       (dq_i[DQ_W-1]),
        .rd_data_i   (rd_data_i),
        .rd_status_i (rd_status_i),
        .status_i    (status_i),
        .dq_o        (dq_o),
        .dq_oe_o     (dq_oe_o)
    );

    assign rd_addr_o = addr_i;
endmodule

// File: rtl/mbf_chk.sv
module mbf_chk #(
    parameter int unsigned ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              rp_n,
    input logic              byte_n,
    input logic              rd_status_i,
    input logic [15:0]       dq_o,
    input logic [15:0]       dq_oe_o,
    input logic              cmd_valid_o,
    input logic [ADDR_W:0]   cmd_addr_o,
    input logic [15:0]       cmd_data_o,
    input logic              cmd_byte_o
);
    logic [ADDR_W:0] unused_addr;
    assign unused_addr = cmd_addr_o;

    assert_oe_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o == 16'h0000 || dq_oe_o == 16'h00FF || dq_oe_o == 16'hFFFF));

    assert_off_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o == 16'h0000) |-> (dq_o == 16'h0000));

    assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    assert_byte_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o != 16'h0000 && !$past(byte_n)) |-> (dq_oe_o == 16'h00FF));

    assert_byte_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_n) |-> (dq_o[15:8] == 8'h00));

    assert_status_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_status_i) |-> (dq_o[15:8] == 8'h00));

    assert_byte_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_byte_o) |-> (cmd_data_o[15:8] == 8'h00));

    assert_ce_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n, 3) |-> (dq_oe_o == 16'h0000));

    assert_rp_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rp_n, 3) |-> (dq_oe_o == 16'h0000 && !cmd_valid_o));

    assert_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_n, 3) |-> (dq_oe_o == 16'h0000));
endmodule

bind mem_bus_front mbf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .we_n        (we_n),
    .rp_n        (rp_n),
    .byte_n      (byte_n),
    .rd_status_i (rd_status_i),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o),
    .cmd_byte_o  (cmd_byte_o)
);

// File: tb/sim_mem_bus_front.sv
`timescale 1ns/1ps
module sim_mem_bus_front;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, rp_n = 1'b1, byte_n = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [15:0]   dq_i = '0;
    logic [15:0]   dq_o, dq_oe_o, rd_data_i, cmd_data_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_status_i = 1'b0;
    logic [7:0]    status_i = 8'h00;
    logic          cmd_valid_o, cmd_byte_o;
    logic [AW:0]   cmd_addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R10";
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC3};
    endfunction

    assign rd_data_i = mem_word(rd_addr_o);

    mem_bus_front #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .rp_n(rp_n),
        .byte_n(byte_n), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .rd_status_i(rd_status_i),
        .status_i(status_i), .cmd_valid_o(cmd_valid_o), .cmd_addr_o(cmd_addr_o),
        .cmd_data_o(cmd_data_o), .cmd_byte_o(cmd_byte_o)
    );

    // Reference model: pin history, synchronized view is three edges old.
    bit          ceh[$], weh[$], oeh[$], rph[$];
    logic [15:0] x_dq = '0, x_oe = '0, x_data = '0;
    logic [AW:0] x_addr = '0;
    logic        x_vld = 1'b0, x_byte = 1'b0;

    task automatic hist_reset();
        ceh = '{1, 1, 1}; weh = '{1, 1, 1}; oeh = '{1, 1, 1}; rph = '{1, 1, 1};
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            hist_reset();
            x_dq = '0; x_oe = '0; x_data = '0; x_addr = '0; x_vld = 0; x_byte = 0;
        end else begin
            bit now_w, was_w, drive;
            ceh.push_front(ce_n); weh.push_front(we_n);
            oeh.push_front(oe_n); rph.push_front(rp_n);
            now_w = !ceh[2] && !weh[2];
            was_w = !ceh[3] && !weh[3];
            x_vld = 0;
            if (now_w && !was_w) begin
                x_byte = !byte_n;
                x_addr = byte_n ? {1'b0, addr_i} : {addr_i, dq_i[15]};
            end
            if (!now_w && was_w && rph[2]) begin
                x_vld  = 1;
                x_data = x_byte ? {8'h00, dq_i[7:0]} : dq_i;
            end
            drive = !ceh[2] && !oeh[2] && weh[2] && rph[2];
            x_oe = '0; x_dq = '0;
            if (drive) begin
                logic [15:0] w;
                w = mem_word(addr_i);
                if (byte_n) begin
                    x_oe = 16'hFFFF;
                    x_dq = rd_status_i ? {8'h00, status_i} : w;
                end else begin
                    x_oe = 16'h00FF;
                    x_dq = rd_status_i ? {8'h00, status_i} : {8'h00, (dq_i[15] ? w[15:8] : w[7:0])};
                end
            end
            while (ceh.size() > 4) begin
                void'(ceh.pop_back()); void'(weh.pop_back());
                void'(oeh.pop_back()); void'(rph.pop_back());
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(phase, "dq_oe_o", 32'(dq_oe_o), 32'(x_oe));
            chk(phase, "dq_o", 32'(dq_o), 32'(x_dq));
            chk(phase, "cmd_valid_o", 32'(cmd_valid_o), 32'(x_vld));
            if (x_vld) begin
                chk(phase, "cmd_addr_o", 32'(cmd_addr_o), 32'(x_addr));
                chk(phase, "cmd_data_o", 32'(cmd_data_o), 32'(x_data));
                chk(phase, "cmd_byte_o", 32'(cmd_byte_o), 32'(x_byte));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write where the write strobe leads/trails (ce first: we controls), or ce controls.
    task automatic do_write(input bit ce_ctrl, input bit mode, input logic [AW-1:0] a,
                            input logic [15:0] d);
        @(negedge clk);
        byte_n = mode; addr_i = a; dq_i = d;
        idle(2);
        if (ce_ctrl) we_n = 0; else ce_n = 0;
        idle(4);
        if (ce_ctrl) ce_n = 0; else we_n = 0;
        idle(5);
        if (ce_ctrl) ce_n = 1; else we_n = 1;
        idle(5);
        ce_n = 1; we_n = 1;
        idle(5);
    endtask

    task automatic do_read(input bit mode, input logic [AW-1:0] a, input bit lsb,
                           input bit stat, input logic [7:0] sv);
        @(negedge clk);
        byte_n = mode; addr_i = a; dq_i = {lsb, 15'h0}; rd_status_i = stat; status_i = sv;
        idle(2);
        ce_n = 0; oe_n = 0;
        idle(6);
        oe_n = 1; ce_n = 1;
        idle(5);
        rd_status_i = 0;
    endtask

    initial begin
        hist_reset();
        idle(4);
        // R10: reset state visible while reset is held
        chk("R10", "dq_oe_o in reset", 32'(dq_oe_o), 0);
        chk("R10", "cmd_valid_o in reset", 32'(cmd_valid_o), 0);
        chk("R10", "cmd_addr_o in reset", 32'(cmd_addr_o), 0);
        chk("R10", "cmd_data_o in reset", 32'(cmd_data_o), 0);
        rst_n = 1;
        idle(3);
        chk("R10", "dq_o after reset", 32'(dq_o), 0);

        phase = "R1 R2";
        do_write(0, 1, 19'h1_2345, 16'hBEEF);
        do_write(1, 1, 19'h7_0F0F, 16'h1234);
        phase = "R3";
        do_write(0, 0, 19'h4_5678, 16'h80A5);
        do_write(1, 0, 19'h0_0001, 16'h7F3C);
        do_write(0, 1, 19'h7_FFFF, 16'hFFFF);
        phase = "R4 R5";
        do_read(1, 19'h0_ABCD, 0, 0, 8'h00);
        do_read(1, 19'h3_1357, 1, 0, 8'h00);
        phase = "R6";
        do_read(0, 19'h0_ABCD, 1, 0, 8'h00);
        do_read(0, 19'h0_ABCD, 0, 0, 8'h00);
        phase = "R7";
        do_read(1, 19'h2_2222, 0, 1, 8'h80);
        do_read(0, 19'h2_2222, 1, 1, 8'h4C);

        phase = "R9";
        @(negedge clk);
        byte_n = 1; addr_i = 19'h5_5555; dq_i = 16'hC0DE;
        idle(2);
        ce_n = 0; oe_n = 0; we_n = 0;
        idle(6);
        we_n = 1;
        idle(6);
        oe_n = 1; ce_n = 1;
        idle(5);

        phase = "R8";
        @(negedge clk);
        rp_n = 0;
        idle(1);
        do_write(0, 1, 19'h6_0006, 16'hDEAD);
        do_read(1, 19'h6_0006, 0, 0, 8'h00);
        rp_n = 1;
        idle(5);
        phase = "R2";
        do_write(1, 0, 19'h6_0007, 16'h00AA);
        idle(5);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule